// File: doc/BRIEF.md
# Carry-Save Overflow Folding Compressor

This block takes a redundant (carry-save) number that has grown one bit beyond its working width and brings it back to that width without changing its residue modulo a fixed modulus n. The input is a sum word and a carry word, each `OUT_W+1` bits wide, and the value they encode is `inSum + 2*inCarry`. The three top-weight bits of the pair form a two-bit overflow count in units of `2^OUT_W`. The block swaps that count for a correction constant (0, `2^OUT_W mod n`, `2*2^OUT_W mod n` or `3*2^OUT_W mod n`). It then adds the correction into the remaining low bits with one row of half and full adders. The result is an `OUT_W`-bit sum and carry pair.

The count bits pass through a `DELAY`-stage register pipeline before they steer the correction multiplexer. The adder row is combinational, so the operands and the three constants must be held steady while the selection catches up. This lets the caller balance the select path against a surrounding pipeline, such as the one that follows a modular multiplier's reduction stage. The constants come from outside the block, so one instance serves any modulus with `n <= 2^OUT_W`.

Top module: `foldCompressor`

## Requirements
- R1: The output value `outSum + 2*outCarry` equals exactly `inSum[OUT_W-1:0] + 2*inCarry[OUT_W-2:0]` plus the selected correction. No bit of this sum is lost.
- R2: The overflow count is `inSum[OUT_W] + inCarry[OUT_W-1] + 2*inCarry[OUT_W]`. It is formed by a half adder on the first two bits, whose carry is ORed with `inCarry[OUT_W]` to give the count's upper bit. It is valid for inputs whose value is below `2^(OUT_W+2)`.
- R3: A count of 0 selects a correction of zero.
- R4: A count of 1 selects `constOne`.
- R5: A count of 2 selects `constTwo`.
- R6: A count of 3 selects `constThree`.
- R7: The correction follows the count of the inputs present `DELAY` rising edges earlier. After only `DELAY-1` edges with new inputs, the previous selection still applies.
- R8: While `rst_n` is low, the select pipeline is cleared and the correction is zero from the first rising edge on.
- R9: When the constants are `k*2^OUT_W mod n` for k = 1, 2, 3, and the input value is below `2^(OUT_W+2)`, then `(outSum + 2*outCarry) mod n` equals `(inSum + 2*inCarry) mod n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the select pipeline |
| inSum | input | OUT_W+1 | Sum word of the incoming carry-save value |
| inCarry | input | OUT_W+1 | Carry word of the incoming value, weight 2 |
| constOne | input | OUT_W | Correction for a count of 1 |
| constTwo | input | OUT_W | Correction for a count of 2 |
| constThree | input | OUT_W | Correction for a count of 3 |
| outSum | output | OUT_W | Sum word of the folded value |
| outCarry | output | OUT_W | Carry word of the folded value, weight 2 |

## Verification
The bench builds the block with `OUT_W = 8` and `DELAY = 3`. Eight-bit constants let it reload three different moduli at run time, and a three-stage select pipeline shows a visible gap between the first input edge and the switched correction. At these sizes it can steer random pairs into each of the four overflow counts, including the corner where a count of 3 leaves the low part just under `2^OUT_W`. It can also catch the stale selection one edge before the pipeline delivers the new one.

// File: rtl/foldPkg.sv
package foldPkg;

  // Strobes from the select pipeline to the correction datapath.
  typedef struct packed {
    logic selHi;
    logic selLo;
  } foldSel_t;

endpackage

// File: rtl/foldCount.sv
module foldCount #(
  parameter int OUT_W = 8
) (
  input  logic [OUT_W:0] inSum,
  input  logic [OUT_W:0] inCarry,
  output logic [1:0]     countRaw
);

  logic halfSum;
  logic halfCarry;

  // Both bits weigh 2^OUT_W; the carry bit above them weighs twice that.
  assign halfSum   = inSum[OUT_W] ^ inCarry[OUT_W-1];
  assign halfCarry = inSum[OUT_W] & inCarry[OUT_W-1];

  assign countRaw = {halfCarry | inCarry[OUT_W], halfSum};

endmodule

// File: rtl/foldSelPipe.sv
module foldSelPipe
  import foldPkg::*;
#(
  parameter int DELAY = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic [1:0] countRaw,
  output foldSel_t sel
);

  generate
    if (DELAY == 0) begin : g_direct
      assign sel.selLo = countRaw[0];
      assign sel.selHi = countRaw[1];
    end else begin : g_stages
      logic [1:0] stage [DELAY];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DELAY; i++) stage[i] <= 2'b00;
        end else begin
          stage[0] <= countRaw;
          for (int i = 1; i < DELAY; i++) stage[i] <= stage[i-1];
        end
      end

      assign sel.selLo = stage[DELAY-1][0];
      assign sel.selHi = stage[DELAY-1][1];
    end
  endgenerate

endmodule

// File: rtl/foldDatapath.sv
module foldDatapath
  import foldPkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic [OUT_W:0]   inSum,
  input  logic [OUT_W:0]   inCarry,
  input  logic [OUT_W-1:0] constOne,
  input  logic [OUT_W-1:0] constTwo,
  input  logic [OUT_W-1:0] constThree,
  input  foldSel_t         sel,
  output logic [OUT_W-1:0] outSum,
  output logic [OUT_W-1:0] outCarry
);

  logic [OUT_W-1:0] pickLow;
  logic [OUT_W-1:0] pickHigh;
  logic [OUT_W-1:0] corr;

  // First level on the low count bit, second level on the high bit.
  assign pickLow  = sel.selLo ? constOne   : '0;
  assign pickHigh = sel.selLo ? constThree : constTwo;
  assign corr     = sel.selHi ? pickHigh   : pickLow;

  // Position 0 has no incoming carry bit: half adder.
  assign outSum[0]   = inSum[0] ^ corr[0];
  assign outCarry[0] = inSum[0] & corr[0];

  // Positions above take sum bit i, carry bit i-1 and correction bit i.
  generate
    for (genvar i = 1; i < OUT_W; i++) begin : g_fa
      logic a;
      logic b;
      logic c;
      assign a           = inSum[i];
      assign b           = inCarry[i-1];
      assign c           = corr[i];
      assign outSum[i]   = a ^ b ^ c;
      assign outCarry[i] = (a & b) | (a & c) | (b & c);
    end
  endgenerate

endmodule

// File: rtl/foldCompressor.sv
module foldCompressor
  import foldPkg::*;
#(
  parameter int OUT_W = 8,
  parameter int DELAY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OUT_W:0]   inSum,
  input  logic [OUT_W:0]   inCarry,
  input  logic [OUT_W-1:0] constOne,
  input  logic [OUT_W-1:0] constTwo,
  input  logic [OUT_W-1:0] constThree,
  output logic [OUT_W-1:0] outSum,
  output logic [OUT_W-1:0] outCarry
);

  logic [1:0] countRaw;
  foldSel_t   sel;

  foldCount #(.OUT_W(OUT_W)) i_count (
    .inSum   (inSum),
    .inCarry (inCarry),
    .countRaw(countRaw)
  );

  foldSelPipe #(.DELAY(DELAY)) i_selPipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .countRaw(countRaw),
    .sel     (sel)
  );

  foldDatapath #(.OUT_W(OUT_W)) i_datapath (
    .inSum     (inSum),
    .inCarry   (inCarry),
    .constOne  (constOne),
    .constTwo  (constTwo),
    .constThree(constThree),
    .sel       (sel),
    .outSum    (outSum),
    .outCarry  (outCarry)
  );

endmodule

// File: rtl/foldCompressorChecker.sv
module foldCompressorChecker #(
  parameter int OUT_W = 8,
  parameter int DELAY = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OUT_W:0]   inSum,
  input logic [OUT_W:0]   inCarry,
  input logic [OUT_W-1:0] constOne,
  input logic [OUT_W-1:0] constTwo,
  input logic [OUT_W-1:0] constThree,
  input logic [OUT_W-1:0] outSum,
  input logic [OUT_W-1:0] outCarry
);

  localparam int VW    = OUT_W + 3;
  localparam int IVW   = 2 * (OUT_W + 1) + 3 * OUT_W;
  localparam int CNT_W = $clog2(DELAY + 2);

  logic [IVW-1:0]   curIn;
  logic [IVW-1:0]   prevIn;
  logic [CNT_W-1:0] stableCnt;
  logic             inMatch;
  logic             settled;
  logic             resetHeld;
  logic [VW-1:0]    lowVal;
  logic [VW-1:0]    outVal;
  logic [1:0]       topCount;

  assign curIn   = {inSum, inCarry, constOne, constTwo, constThree};
  assign inMatch = (curIn == prevIn);
  assign settled = (DELAY == 0) || (inMatch && (int'(stableCnt) + 1 >= DELAY));
  assign lowVal  = VW'(inSum[OUT_W-1:0]) + (VW'(inCarry[OUT_W-2:0]) << 1);
  assign outVal  = VW'(outSum) + (VW'(outCarry) << 1);
  assign topCount = 2'(inSum[OUT_W]) + 2'(inCarry[OUT_W-1]) + {inCarry[OUT_W], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevIn    <= '0;
      stableCnt <= '0;
    end else begin
      prevIn <= curIn;
      if (!inMatch) stableCnt <= '0;
      else if (int'(stableCnt) < DELAY) stableCnt <= stableCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) resetHeld <= !rst_n;

  AST_CORR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && topCount == 2'd0) |-> (outVal == lowVal)); // R3

  AST_CORR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && topCount == 2'd1) |-> (outVal == lowVal + VW'(constOne))); // R4

  AST_CORR_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && topCount == 2'd2) |-> (outVal == lowVal + VW'(constTwo))); // R5

  AST_CORR_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && topCount == 2'd3) |-> (outVal == lowVal + VW'(constThree))); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (resetHeld === 1'b1 && !rst_n) |-> (outVal == lowVal)); // R8

endmodule

bind foldCompressor foldCompressorChecker #(.OUT_W(OUT_W), .DELAY(DELAY)) i_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .inSum     (inSum),
  .inCarry   (inCarry),
  .constOne  (constOne),
  .constTwo  (constTwo),
  .constThree(constThree),
  .outSum    (outSum),
  .outCarry  (outCarry)
);

// File: tb/test_foldCompressor.sv
module test_foldCompressor;

  localparam int OUT_W = 8;
  localparam int DELAY = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [OUT_W:0]   inSum = '0;
  logic [OUT_W:0]   inCarry = '0;
  logic [OUT_W-1:0] constOne = '0;
  logic [OUT_W-1:0] constTwo = '0;
  logic [OUT_W-1:0] constThree = '0;
  logic [OUT_W-1:0] outSum;
  logic [OUT_W-1:0] outCarry;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int modulus = 251;

  always #10 clk = ~clk;

  foldCompressor #(.OUT_W(OUT_W), .DELAY(DELAY)) i_foldCompressor (
    .clk(clk), .rst_n(rst_n), .inSum(inSum), .inCarry(inCarry),
    .constOne(constOne), .constTwo(constTwo), .constThree(constThree),
    .outSum(outSum), .outCarry(outCarry)
  );

  function automatic int countOf(logic [OUT_W:0] s, logic [OUT_W:0] c);
    return int'(s[OUT_W]) + int'(c[OUT_W-1]) + 2 * int'(c[OUT_W]);
  endfunction

  function automatic int lowOf(logic [OUT_W:0] s, logic [OUT_W:0] c);
    return int'(s[OUT_W-1:0]) + 2 * int'(c[OUT_W-2:0]);
  endfunction

  function automatic int valueOf(logic [OUT_W:0] s, logic [OUT_W:0] c);
    return int'(s) + 2 * int'(c);
  endfunction

  function automatic int constFor(int k, int n);
    return (k << OUT_W) % n;
  endfunction

  function automatic int corrFor(int cnt, int n);
    return (cnt == 0) ? 0 : constFor(cnt, n);
  endfunction

  function automatic int outValue();
    return int'(outSum) + 2 * int'(outCarry);
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic loadModulus(int n);
    @(negedge clk);
    modulus    = n;
    constOne   = OUT_W'(constFor(1, n));
    constTwo   = OUT_W'(constFor(2, n));
    constThree = OUT_W'(constFor(3, n));
  endtask

  task automatic applySettled(logic [OUT_W:0] s, logic [OUT_W:0] c);
    @(negedge clk);
    inSum   = s;
    inCarry = c;
    repeat (DELAY) @(posedge clk);
    @(negedge clk);
  endtask

  // Exact value (R1..R6) and residue (R9) of a settled output.
  task automatic checkSettled(string req, logic [OUT_W:0] s, logic [OUT_W:0] c);
    int cnt;
    cnt = countOf(s, c);
    check(req, outValue(), lowOf(s, c) + corrFor(cnt, modulus));
    check("R9", outValue() % modulus, valueOf(s, c) % modulus);
  endtask

  task automatic makePair(int cnt, output logic [OUT_W:0] s, output logic [OUT_W:0] c);
    bit pick;
    bit ok;
    ok = 1'b0;
    while (!ok) begin
      s = (OUT_W+1)'($urandom);
      c = (OUT_W+1)'($urandom);
      pick = 1'($urandom);
      case (cnt)
        0: begin s[OUT_W] = 1'b0; c[OUT_W-1] = 1'b0; c[OUT_W] = 1'b0; end
        1: begin s[OUT_W] = pick; c[OUT_W-1] = !pick; c[OUT_W] = 1'b0; end
        2: begin s[OUT_W] = pick; c[OUT_W-1] = pick; c[OUT_W] = !pick; end
        default: begin s[OUT_W] = pick; c[OUT_W-1] = !pick; c[OUT_W] = 1'b1; end
      endcase
      ok = valueOf(s, c) < (1 << (OUT_W + 2));
    end
  endtask

  initial begin
    logic [OUT_W:0] s;
    logic [OUT_W:0] c;
    int moduli [3];
    void'($urandom(32'd20240611));
    moduli[0] = 251; moduli[1] = 193; moduli[2] = 137;

    // R8: reset holds the correction at zero even with a count of 3 present.
    constOne = OUT_W'(constFor(1, 251));
    constTwo = OUT_W'(constFor(2, 251));
    constThree = OUT_W'(constFor(3, 251));
    inSum   = 9'h155;
    inCarry = 9'h100;
    repeat (DELAY + 1) @(posedge clk);
    @(negedge clk);
    check("R8", outValue(), lowOf(9'h155, 9'h100));
    rst_n = 1'b1;

    // R7: new count appears only after DELAY edges.
    applySettled(9'h0a3, 9'h011);
    check("R3", outValue(), lowOf(9'h0a3, 9'h011));
    @(negedge clk);
    inSum = 9'h1a3;
    repeat (DELAY - 1) @(posedge clk);
    @(negedge clk);
    check("R7", outValue(), lowOf(9'h1a3, 9'h011));
    @(negedge clk);
    check("R7", outValue(), lowOf(9'h1a3, 9'h011) + constFor(1, 251));

    // Directed corners: largest low parts for counts 2 and 3.
    applySettled(9'h0ff, 9'h17f);
    checkSettled("R5", 9'h0ff, 9'h17f);
    applySettled(9'h1ff, 9'h100);
    checkSettled("R6", 9'h1ff, 9'h100);
    applySettled(9'h0ff, 9'h180);
    checkSettled("R6", 9'h0ff, 9'h180);
    applySettled(9'h001, 9'h080);
    checkSettled("R4", 9'h001, 9'h080);
    applySettled(9'h0ff, 9'h07f);
    checkSettled("R1", 9'h0ff, 9'h07f);

    // Random sweep: each modulus, each count (R2 forms the count).
    for (int m = 0; m < 3; m++) begin
      loadModulus(moduli[m]);
      for (int cnt = 0; cnt < 4; cnt++) begin
        for (int t = 0; t < 12; t++) begin
          makePair(cnt, s, c);
          applySettled(s, c);
          case (cnt)
            0: checkSettled("R3", s, c);
            1: checkSettled("R4", s, c);
            2: checkSettled("R5", s, c);
            default: checkSettled("R6", s, c);
          endcase
          check("R2", countOf(s, c), cnt);
        end
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule